// File: doc/BRIEF.md
# Ping-Pong Endpoint Buffer Controller

This block manages a two-bank data buffer for a single USB device endpoint. At any moment one bank belongs to the serial interface engine, which fills it from received OUT packets or drains it for IN transmission. The other bank belongs to the CPU, which reads received data or prepares the next packet to send. When the engine finishes with its bank and the CPU side is free, the banks swap roles and a sticky buffer-ready interrupt is raised.

A 16-bit status/control word gives the CPU three things. It can read the byte count in the engine-side bank and a busy flag. On an OUT endpoint in continuous mode, it can force the engine-side bank to close and swap. On an IN endpoint, it can discard a bank that is waiting to be sent. Endpoint direction, continuous mode and whether the handshake response is NAK are plain inputs. A forced action that is not permitted is dropped and sets a sticky error flag.

Top module: `epBufCtrl`

## Requirements
- R1: After reset, the status word reads 0x0000. `cpuBankFull`, `readyIrq`, `errFlag` and `cpuLen` are all 0.
- R2: Status word layout: bits 15 and 14 read 0. Bit 13 (toggle strobe) and bit 12 (clear strobe) always read 0. Bit 11 is the busy flag. Bits 10..0 give the byte count of the engine-side bank.
- R3: OUT endpoint, continuous mode off: each accepted engine byte is stored in order and counted. When a packet-end pulse arrives while the CPU bank is empty, the banks swap one cycle after the pulse is registered. After the swap, `cpuBankFull`=1, `cpuLen` equals the received count, the bytes read back in arrival order on `cpuRdData`, the engine-side count is 0 and `readyIrq`=1.
- R4: OUT endpoint: a bank closed while the CPU bank is still full waits without swapping. `cpuLen` and the engine-side count stay unchanged until `cpuRelease`. The swap then happens one cycle after the release is registered.
- R5: A toggle write (bit 13 = 1) on an OUT endpoint is accepted when three conditions hold: continuous mode is on, the handshake is NAK, and busy is 0. The banks then swap even if the CPU bank is full. After the swap, `cpuLen` equals the previous engine-side count, the new engine-side count is 0, `cpuBankFull`=1 and `readyIrq`=1.
- R6: IN endpoint: CPU bytes are stored and counted. `cpuCommit` marks the CPU bank full. If the engine-side bank is idle, the banks swap one cycle later: the engine-side count becomes the written length, the bytes appear in order on `sieRdData`, `cpuBankFull` returns to 0 and `readyIrq`=1. A commit made while the engine bank is loaded waits for `sieTxDone`, which empties that bank.
- R7: A clear write (bit 12 = 1) on an IN endpoint while not busy discards the loaded engine-side bank and sets its count to 0. A pending commit then moves in one cycle later.
- R8: Busy is set by the first accepted engine byte access of a packet. It is cleared by the packet-end pulse (`sieRxDone` for OUT, `sieTxDone` for IN).
- R9: The following writes change no buffer state and set the sticky `errFlag`: toggle on IN, clear on OUT, either strobe while busy, and toggle without continuous mode or without NAK. A write with both strobe bits 0 has no effect and raises no error.
- R10: `readyIrq` stays set until an `irqClr` pulse clears it.
- R11: A bank's byte count saturates at DEPTH. Further bytes are dropped.
- R12: OUT endpoint in continuous mode: a packet-end pulse clears busy but neither closes nor swaps the bank. Bytes of successive packets accumulate in the engine-side bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epDirIn | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| contMode | input | 1 | Continuous receive/transmit mode enable |
| hsNak | input | 1 | Endpoint handshake response currently NAK |
| sieWrEn | input | 1 | Engine writes one received byte (OUT) |
| sieWrData | input | DATA_W | Received byte |
| sieRxDone | input | 1 | Engine packet-end pulse (OUT) |
| sieRdEn | input | 1 | Engine takes one byte for transmit (IN) |
| sieRdData | output | DATA_W | Byte at engine read position |
| sieTxDone | input | 1 | Engine transmit-complete pulse (IN) |
| cpuWrEn | input | 1 | CPU writes one byte (IN) |
| cpuWrData | input | DATA_W | CPU byte |
| cpuCommit | input | 1 | CPU marks its bank ready to send (IN) |
| cpuRdEn | input | 1 | CPU consumes one byte (OUT) |
| cpuRdData | output | DATA_W | Byte at CPU read position |
| cpuRelease | input | 1 | CPU done with its bank (OUT) |
| ctrlWrEn | input | 1 | Write strobe for the status/control word |
| ctrlWrData | input | 16 | Written control word |
| ctrlRdData | output | 16 | Status word |
| cpuLen | output | 11 | Byte count of the CPU-side bank |
| cpuBankFull | output | 1 | OUT: data ready to read; IN: bank committed |
| readyIrq | output | 1 | Sticky buffer-ready interrupt |
| irqClr | input | 1 | Clears readyIrq |
| errFlag | output | 1 | Sticky illegal-write flag |

## Verification
The swap logic is exercised in four situations. An OUT packet arrives with the CPU bank empty, which must swap at once. An OUT packet arrives with the CPU bank full, which must wait for release. Continuous-mode OUT traffic must accumulate until a forced toggle. An IN commit arrives both with the engine bank idle and with it loaded, so that an immediate swap can be told apart from a deferred one. Each case checks the counts and the byte order on both sides, so a bank or pointer mix-up shows up as wrong data rather than only as a wrong flag. The forced operations are tried under every blocking condition in turn (wrong direction, busy, mode off, no NAK), and each must leave the counts intact while setting the error flag.

// File: rtl/epBufPkg.sv
package epBufPkg;
  localparam int STAT_W    = 16;
  localparam int LEN_FLD_W = 11;
  localparam int TOG_BIT   = 13;
  localparam int CLR_BIT   = 12;
  localparam int BUSY_BIT  = 11;

  // Strobes from the sequencer to the bank datapath
  typedef struct packed {
    logic swap;      // exchange bank roles
    logic dirIn;     // endpoint direction (1 = IN)
    logic sieWr;     // store engine byte in engine bank
    logic cpuWr;     // store CPU byte in CPU bank
    logic sieRd;     // advance engine read position
    logic cpuRd;     // advance CPU read position
    logic sieFlush;  // empty engine bank
  } bufStrobe_t;
endpackage

// File: rtl/epBufSeq.sv
module epBufSeq
  import epBufPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       epDirIn,
  input  logic       contMode,
  input  logic       hsNak,
  input  logic       sieWrEn,
  input  logic       sieRxDone,
  input  logic       sieRdEn,
  input  logic       sieTxDone,
  input  logic       cpuWrEn,
  input  logic       cpuCommit,
  input  logic       cpuRdEn,
  input  logic       cpuRelease,
  input  logic       ctrlWrEn,
  input  logic       togBit,
  input  logic       clrBit,
  input  logic       irqClr,
  output bufStrobe_t str,
  output logic       busy,
  output logic       cpuFull,
  output logic       readyIrq,
  output logic       errFlag
);
  logic busyQ, sieClosedQ, sieLoadedQ, cpuFullQ, irqQ, errQ;
  logic togReq, clrReq, togOk, clrOk, badWr;
  logic outSwap, inSwap, pktEnd, sieAcc;

  always_comb begin
    togReq  = ctrlWrEn & togBit;
    clrReq  = ctrlWrEn & clrBit;
    togOk   = togReq & ~epDirIn & ~busyQ & contMode & hsNak;
    clrOk   = clrReq & epDirIn & ~busyQ;
    badWr   = (togReq & ~togOk) | (clrReq & ~clrOk);
    outSwap = ~epDirIn & ((sieClosedQ & ~cpuFullQ) | togOk);
    inSwap  = epDirIn & cpuFullQ & ~sieLoadedQ;
    pktEnd  = (~epDirIn & sieRxDone) | (epDirIn & sieTxDone);

    str.swap     = outSwap | inSwap;
    str.dirIn    = epDirIn;
    str.sieWr    = ~epDirIn & sieWrEn & ~sieClosedQ & ~outSwap;
    str.cpuWr    = epDirIn & cpuWrEn & ~cpuFullQ;
    str.sieRd    = epDirIn & sieRdEn & sieLoadedQ & ~clrOk;
    str.cpuRd    = ~epDirIn & cpuRdEn & cpuFullQ & ~outSwap;
    str.sieFlush = epDirIn & sieLoadedQ & (clrOk | sieTxDone);
    sieAcc       = str.sieWr | str.sieRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      sieClosedQ <= 1'b0;
      sieLoadedQ <= 1'b0;
      cpuFullQ   <= 1'b0;
      irqQ       <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      // busy tracks an engine packet in progress
      if (pktEnd)      busyQ <= 1'b0;
      else if (sieAcc) busyQ <= 1'b1;

      // OUT: bank closes at packet end unless continuous mode is on
      if (outSwap)
        sieClosedQ <= 1'b0;
      else if (~epDirIn & sieRxDone & ~contMode)
        sieClosedQ <= 1'b1;

      // IN: engine bank loaded by a swap, emptied by send or clear
      if (inSwap)            sieLoadedQ <= 1'b1;
      else if (str.sieFlush) sieLoadedQ <= 1'b0;

      if (epDirIn) begin
        if (inSwap)         cpuFullQ <= 1'b0;
        else if (cpuCommit) cpuFullQ <= 1'b1;
      end else begin
        if (outSwap)         cpuFullQ <= 1'b1;
        else if (cpuRelease) cpuFullQ <= 1'b0;
      end

      if (str.swap)    irqQ <= 1'b1;
      else if (irqClr) irqQ <= 1'b0;

      errQ <= errQ | badWr;
    end
  end

  assign busy     = busyQ;
  assign cpuFull  = cpuFullQ;
  assign readyIrq = irqQ;
  assign errFlag  = errQ;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && (togBit || clrBit) && busyQ) |=> (errFlag && !irqQ || errFlag));

  // R3
  swap_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.swap |=> readyIrq);

  // R8
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> !busy);
endmodule

// File: rtl/epBufData.sv
module epBufData
  import epBufPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bufStrobe_t           str,
  input  logic [DATA_W-1:0]    sieWrData,
  input  logic [DATA_W-1:0]    cpuWrData,
  output logic [DATA_W-1:0]    sieRdData,
  output logic [DATA_W-1:0]    cpuRdData,
  output logic [LEN_FLD_W-1:0] sieLen,
  output logic [LEN_FLD_W-1:0] cpuLen
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic             selQ;  // index of the engine-side bank
  logic [CNT_W-1:0] siePtrQ, cpuPtrQ;
  logic [CNT_W-1:0] bankLen [2];
  logic [DATA_W-1:0] bankRd [2];
  logic [CNT_W-1:0] sieCnt, cpuCnt;

  assign sieCnt = bankLen[selQ];
  assign cpuCnt = bankLen[~selQ];

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic              isSie, wrHit, clrHit;
    logic [DATA_W-1:0] wrWord;
    logic [CNT_W-1:0]  rdPtr;
    logic [CNT_W-1:0]  lenQ;
    logic [DATA_W-1:0] memQ [DEPTH];

    always_comb begin
      isSie  = (selQ == 1'(b));
      wrHit  = isSie ? str.sieWr : str.cpuWr;
      wrWord = isSie ? sieWrData : cpuWrData;
      rdPtr  = isSie ? siePtrQ : cpuPtrQ;
      // the bank that the producer fills next starts empty
      clrHit = (str.swap & (str.dirIn == isSie)) | (str.sieFlush & isSie);
    end

    always_ff @(posedge clk) begin
      if (!rstN)                      lenQ <= '0;
      else if (clrHit)                lenQ <= '0;
      else if (wrHit && lenQ < CAP)   lenQ <= lenQ + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wrHit && !clrHit && lenQ < CAP)
        memQ[lenQ[PTR_W-1:0]] <= wrWord;
    end

    assign bankLen[b] = lenQ;
    assign bankRd[b]  = memQ[rdPtr[PTR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= 1'b0;
      siePtrQ <= '0;
      cpuPtrQ <= '0;
    end else begin
      if (str.swap) selQ <= ~selQ;

      if ((str.swap && str.dirIn) || str.sieFlush)
        siePtrQ <= '0;
      else if (str.sieRd && siePtrQ < sieCnt)
        siePtrQ <= siePtrQ + 1'b1;

      if (str.swap && !str.dirIn)
        cpuPtrQ <= '0;
      else if (str.cpuRd && cpuPtrQ < cpuCnt)
        cpuPtrQ <= cpuPtrQ + 1'b1;
    end
  end

  assign sieRdData = bankRd[selQ];
  assign cpuRdData = bankRd[~selQ];
  assign sieLen    = LEN_FLD_W'(sieCnt);
  assign cpuLen    = LEN_FLD_W'(cpuCnt);

  // R11
  len_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sieCnt <= CAP) && (cpuCnt <= CAP));

  // R5
  swap_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.swap && !str.dirIn) |=> (cpuLen == $past(sieLen)) && (sieLen == '0));

  // R6
  in_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.swap && str.dirIn) |=> (sieLen == $past(cpuLen)) && (cpuLen == '0));
endmodule

// File: rtl/epBufCtrl.sv
module epBufCtrl
  import epBufPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 epDirIn,
  input  logic                 contMode,
  input  logic                 hsNak,
  input  logic                 sieWrEn,
  input  logic [DATA_W-1:0]    sieWrData,
  input  logic                 sieRxDone,
  input  logic                 sieRdEn,
  output logic [DATA_W-1:0]    sieRdData,
  input  logic                 sieTxDone,
  input  logic                 cpuWrEn,
  input  logic [DATA_W-1:0]    cpuWrData,
  input  logic                 cpuCommit,
  input  logic                 cpuRdEn,
  output logic [DATA_W-1:0]    cpuRdData,
  input  logic                 cpuRelease,
  input  logic                 ctrlWrEn,
  input  logic [STAT_W-1:0]    ctrlWrData,
  output logic [STAT_W-1:0]    ctrlRdData,
  output logic [LEN_FLD_W-1:0] cpuLen,
  output logic                 cpuBankFull,
  output logic                 readyIrq,
  input  logic                 irqClr,
  output logic                 errFlag
);
  bufStrobe_t          str;
  logic                busy;
  logic [LEN_FLD_W-1:0] sieLen;

  epBufSeq uSeq (
    .clk        (clk),
    .rstN       (rstN),
    .epDirIn    (epDirIn),
    .contMode   (contMode),
    .hsNak      (hsNak),
    .sieWrEn    (sieWrEn),
    .sieRxDone  (sieRxDone),
    .sieRdEn    (sieRdEn),
    .sieTxDone  (sieTxDone),
    .cpuWrEn    (cpuWrEn),
    .cpuCommit  (cpuCommit),
    .cpuRdEn    (cpuRdEn),
    .cpuRelease (cpuRelease),
    .ctrlWrEn   (ctrlWrEn),
    .togBit     (ctrlWrData[TOG_BIT]),
    .clrBit     (ctrlWrData[CLR_BIT]),
    .irqClr     (irqClr),
    .str        (str),
    .busy       (busy),
    .cpuFull    (cpuBankFull),
    .readyIrq   (readyIrq),
    .errFlag    (errFlag)
  );

  epBufData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .sieWrData (sieWrData),
    .cpuWrData (cpuWrData),
    .sieRdData (sieRdData),
    .cpuRdData (cpuRdData),
    .sieLen    (sieLen),
    .cpuLen    (cpuLen)
  );

  // strobe bits and reserved bits always read back as zero
  assign ctrlRdData = {2'b00, 1'b0, 1'b0, busy, sieLen};
endmodule

// File: tb/epBufCtrl_test.sv
module epBufCtrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic epDirIn = 1'b0, contMode = 1'b0, hsNak = 1'b1;
  logic sieWrEn = 1'b0, sieRxDone = 1'b0, sieRdEn = 1'b0, sieTxDone = 1'b0;
  logic cpuWrEn = 1'b0, cpuCommit = 1'b0, cpuRdEn = 1'b0, cpuRelease = 1'b0;
  logic ctrlWrEn = 1'b0, irqClr = 1'b0;
  logic [DW-1:0] sieWrData = '0, cpuWrData = '0;
  logic [15:0] ctrlWrData = '0;
  logic [DW-1:0] sieRdData, cpuRdData;
  logic [15:0] ctrlRdData;
  logic [10:0] cpuLen;
  logic cpuBankFull, readyIrq, errFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  epBufCtrl #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .epDirIn(epDirIn), .contMode(contMode), .hsNak(hsNak),
    .sieWrEn(sieWrEn), .sieWrData(sieWrData), .sieRxDone(sieRxDone),
    .sieRdEn(sieRdEn), .sieRdData(sieRdData), .sieTxDone(sieTxDone),
    .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuCommit(cpuCommit),
    .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData), .cpuRelease(cpuRelease),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .cpuLen(cpuLen), .cpuBankFull(cpuBankFull), .readyIrq(readyIrq),
    .irqClr(irqClr), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all stimulus tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic sieWrite(input logic [DW-1:0] d);
    sieWrEn = 1'b1; sieWrData = d; idle(1); sieWrEn = 1'b0;
  endtask

  task automatic cpuWrite(input logic [DW-1:0] d);
    cpuWrEn = 1'b1; cpuWrData = d; idle(1); cpuWrEn = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [15:0] w);
    ctrlWrEn = 1'b1; ctrlWrData = w; idle(1); ctrlWrEn = 1'b0; ctrlWrData = '0;
  endtask

  task automatic pulseRxDone();   sieRxDone = 1'b1;  idle(1); sieRxDone = 1'b0;  endtask
  task automatic pulseTxDone();   sieTxDone = 1'b1;  idle(1); sieTxDone = 1'b0;  endtask
  task automatic pulseCommit();   cpuCommit = 1'b1;  idle(1); cpuCommit = 1'b0;  endtask
  task automatic pulseRelease();  cpuRelease = 1'b1; idle(1); cpuRelease = 1'b0; endtask
  task automatic pulseIrqClr();   irqClr = 1'b1;     idle(1); irqClr = 1'b0;     endtask

  task automatic cpuReadExpect(input string req, input logic [DW-1:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      chk(req, cpuRdData, base + DW'(i));
      cpuRdEn = 1'b1; idle(1); cpuRdEn = 1'b0;
    end
  endtask

  task automatic testReset();
    doReset();
    chk("R1 status", ctrlRdData, 16'h0000);
    chk("R1 cpuBankFull", cpuBankFull, 0);
    chk("R1 readyIrq", readyIrq, 0);
    chk("R1 errFlag", errFlag, 0);
    chk("R1 cpuLen", cpuLen, 0);
  endtask

  task automatic testOutBasic();
    epDirIn = 1'b0; contMode = 1'b0;
    for (int i = 0; i < 5; i++) sieWrite(8'hA0 + DW'(i));
    chk("R2 R8 busy and count", ctrlRdData, 16'h0805);
    pulseRxDone();
    chk("R8 busy cleared", ctrlRdData, 16'h0005);
    chk("R3 no swap yet", cpuBankFull, 0);
    idle(1);
    chk("R3 sie count zero", ctrlRdData, 16'h0000);
    chk("R3 cpuLen", cpuLen, 5);
    chk("R3 cpuBankFull", cpuBankFull, 1);
    chk("R3 irq", readyIrq, 1);
    cpuReadExpect("R3 data order", 8'hA0, 5);
  endtask

  task automatic testOutWait();
    for (int i = 0; i < 3; i++) sieWrite(8'hB0 + DW'(i));
    pulseRxDone();
    idle(3);
    chk("R4 cpuLen held", cpuLen, 5);
    chk("R4 sie count held", ctrlRdData, 16'h0003);
    chk("R4 full held", cpuBankFull, 1);
    pulseRelease();
    chk("R4 released", cpuBankFull, 0);
    idle(1);
    chk("R4 cpuLen after", cpuLen, 3);
    chk("R4 full after", cpuBankFull, 1);
    chk("R4 sie count after", ctrlRdData, 16'h0000);
    cpuReadExpect("R4 data order", 8'hB0, 3);
    pulseRelease();
    pulseIrqClr();
    chk("R10 irq cleared", readyIrq, 0);
    idle(2);
    chk("R10 irq stays clear", readyIrq, 0);
  endtask

  task automatic testForceToggle();
    sieWrite(8'hD0);
    pulseRxDone();
    idle(1);
    chk("R3 cpu bank full before toggle", cpuBankFull, 1);
    contMode = 1'b1; hsNak = 1'b1;
    sieWrite(8'hC0); sieWrite(8'hC1);
    pulseRxDone();
    idle(2);
    chk("R12 no swap in continuous mode", ctrlRdData, 16'h0002);
    chk("R12 cpuLen unchanged", cpuLen, 1);
    sieWrite(8'hC2); sieWrite(8'hC3);
    pulseRxDone();
    chk("R12 accumulated", ctrlRdData, 16'h0004);
    ctrlWrite(16'h2000);
    chk("R5 cpuLen", cpuLen, 4);
    chk("R5 sie count zero", ctrlRdData, 16'h0000);
    chk("R5 full", cpuBankFull, 1);
    chk("R5 irq", readyIrq, 1);
    chk("R5 no error", errFlag, 0);
    cpuReadExpect("R5 data order", 8'hC0, 4);
    sieWrite(8'hE0);
    chk("R8 busy set", ctrlRdData, 16'h0801);
    ctrlWrite(16'h2000);
    chk("R9 busy toggle err", errFlag, 1);
    chk("R9 busy toggle status", ctrlRdData, 16'h0801);
    chk("R9 busy toggle cpuLen", cpuLen, 4);
  endtask

  task automatic testIn();
    doReset();
    epDirIn = 1'b1; contMode = 1'b0;
    for (int i = 0; i < 4; i++) cpuWrite(8'hF0 + DW'(i));
    chk("R6 cpuLen written", cpuLen, 4);
    pulseCommit();
    chk("R6 committed", cpuBankFull, 1);
    idle(1);
    chk("R6 sie count", ctrlRdData, 16'h0004);
    chk("R6 cpu free", cpuBankFull, 0);
    chk("R6 irq", readyIrq, 1);
    for (int i = 0; i < 4; i++) begin
      chk("R6 tx order", sieRdData, 8'hF0 + DW'(i));
      sieRdEn = 1'b1; idle(1); sieRdEn = 1'b0;
    end
    chk("R8 busy in tx", ctrlRdData, 16'h0804);
    cpuWrite(8'h90); cpuWrite(8'h91);
    pulseCommit();
    idle(2);
    chk("R6 commit pending", cpuBankFull, 1);
    pulseTxDone();
    chk("R6 tx done empties", ctrlRdData, 16'h0000);
    idle(1);
    chk("R6 pending moves in", ctrlRdData, 16'h0002);
    chk("R6 cpu free again", cpuBankFull, 0);
  endtask

  task automatic testClear();
    for (int i = 0; i < 3; i++) cpuWrite(8'h70 + DW'(i));
    pulseCommit();
    idle(1);
    chk("R7 commit waits", cpuBankFull, 1);
    ctrlWrite(16'h1000);
    chk("R7 cleared", ctrlRdData, 16'h0000);
    chk("R7 no error", errFlag, 0);
    idle(1);
    chk("R7 pending loaded", ctrlRdData, 16'h0003);
    chk("R7 first byte", sieRdData, 8'h70);
  endtask

  task automatic testIllegal();
    doReset();
    epDirIn = 1'b0; contMode = 1'b0; hsNak = 1'b1;
    ctrlWrite(16'h0000);
    chk("R9 zero write no err", errFlag, 0);
    sieWrite(8'h11); pulseRxDone();
    ctrlWrite(16'h1000);
    chk("R9 clear on OUT err", errFlag, 1);
    idle(1);
    chk("R9 clear on OUT no discard", cpuLen, 1);
    doReset();
    epDirIn = 1'b1;
    cpuWrite(8'h22); pulseCommit(); idle(1);
    ctrlWrite(16'h2000);
    chk("R9 toggle on IN err", errFlag, 1);
    chk("R9 toggle on IN status", ctrlRdData, 16'h0001);
    doReset();
    epDirIn = 1'b0; contMode = 1'b1; hsNak = 1'b0;
    sieWrite(8'h33); sieWrite(8'h34); pulseRxDone();
    ctrlWrite(16'h2000);
    chk("R9 toggle without NAK err", errFlag, 1);
    chk("R9 toggle without NAK status", ctrlRdData, 16'h0002);
    chk("R9 toggle without NAK full", cpuBankFull, 0);
    doReset();
    epDirIn = 1'b0; contMode = 1'b0; hsNak = 1'b1;
    sieWrite(8'h44); pulseRxDone(); idle(1);
    sieWrite(8'h45); pulseRxDone();
    ctrlWrite(16'h2000);
    chk("R9 toggle without continuous err", errFlag, 1);
    chk("R9 toggle without continuous cpuLen", cpuLen, 1);
    hsNak = 1'b1;
  endtask

  task automatic testSaturate();
    doReset();
    epDirIn = 1'b0; contMode = 1'b0;
    for (int i = 0; i < DEPTH + 6; i++) sieWrite(DW'(i));
    chk("R11 count saturates", ctrlRdData, 16'h0800 | 16'(DEPTH));
    pulseRxDone(); idle(1);
    chk("R11 cpuLen saturated", cpuLen, DEPTH);
    cpuReadExpect("R11 first bytes kept", 8'h00, 2);
  endtask

  initial begin
    idle(1);
    testReset();
    testOutBasic();
    testOutWait();
    testForceToggle();
    testIn();
    testClear();
    testIllegal();
    testSaturate();
    testReset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule